// File: doc/BRIEF.md
# Masked-Write GPIO Register Bank

This block is the register file of a 32-pin general-purpose I/O port on a simple memory-mapped bus. The bus has an address, a write-data word, a write strobe and a read-data word. Every 32-bit control register is held as two 16-bit halves at neighbouring word addresses. In every bus write, bits [31:16] act as per-bit write enables for bits [15:0]. Software can therefore set or clear any single pin's control bit in one write, with no read-modify-write sequence and no lock around it.

The bank drives the pin output value and output-enable vectors. It also drives the configuration vectors that the separate interrupt-detection and debounce blocks consume. It samples the pin input vector through a synchronizer and exposes the result as a read-only word. It reads back the pending and raw interrupt vectors supplied by the interrupt block. It turns masked writes to the end-of-interrupt address into single-cycle acknowledge pulses. A fixed version word identifies the register layout to software.

Top module: `gpio_mw_bank`

## Requirements
- R1: The ten configuration registers (each written to the control output named in brackets) sit at base N = 0x00 + 8·k for k = 0 to 9:
  - k=0 output value (`pin_out`)
  - k=1 direction (`pin_oe`)
  - k=2 interrupt enable (`irq_en`)
  - k=3 interrupt mask (`irq_mask`)
  - k=4 edge/level select (`irq_edge`)
  - k=5 polarity (`irq_pol`)
  - k=6 both-edge (`irq_both`)
  - k=7 debounce enable (`deb_en`)
  - k=8 debounce divider enable (`deb_div_en`)
  - k=9 debounce divider value (`deb_div_val`)

  For each register, pins 0–15 are in the word at N and pins 16–31 are in the word at N+4.
- R2: On a write to a split word, stored bit i (0–15) of that half changes only when write-data bit i+16 is 1. All other stored bits keep their value.
- R3: When the enable bit is set, a data bit of 1 sets the stored bit and a data bit of 0 clears it.
- R4: `pin_out` follows the output-value register. `pin_oe[i]` is 1 (pin is an output) exactly when direction bit i is 1.
- R5: A read of a split word returns the stored 16 bits in [15:0] and zeros in [31:16]. `bus_rdata` shows the word addressed in the previous cycle.
- R6: The word at 0x78 reads as the constant 0x01000C2B, and writes to it have no effect.
- R7: The word at 0x70 returns `pin_in` after two synchronizing flops as a plain 32-bit value. Writes to it have no effect.
- R8: The words at 0x50 and 0x58 return `irq_stat_in` and `irq_raw_in` unchanged, as 32-bit values.
- R9: A write to 0x60 (pins 0–15) or 0x64 (pins 16–31) raises `eoi_pulse` for one cycle on each bit whose enable and data bits are both 1. Both of these words read as zero.
- R10: Reset (synchronous, active high) clears every stored register, so all pins start as inputs and all interrupts start disabled.
- R11: Reads of unmapped word addresses return zero, and writes to them change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data: [31:16] enables, [15:0] values |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pin input levels (asynchronous) |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| irq_en | output | 32 | Interrupt enable per pin |
| irq_mask | output | 32 | Interrupt mask per pin |
| irq_edge | output | 32 | Edge/level select per pin |
| irq_pol | output | 32 | Interrupt polarity per pin |
| irq_both | output | 32 | Both-edge detect per pin |
| deb_en | output | 32 | Debounce enable per pin |
| deb_div_en | output | 32 | Debounce divider enable per pin |
| deb_div_val | output | 32 | Debounce divider value |
| irq_stat_in | input | 32 | Pending interrupt vector from detector |
| irq_raw_in | input | 32 | Raw interrupt vector from detector |
| eoi_pulse | output | 32 | One-cycle end-of-interrupt strobes |

## Verification
Most faults in the bank appear at the control outputs on the clock edge that takes the write. Examples are a stored bit that is wrong, a write enable that lands in the wrong half, or a decode that hits the wrong register. Every control vector is a port, so such a fault is visible at once without any read-back. A fault in the read path shows on `bus_rdata` one cycle after the address. The two-cycle delay on the input sample shows on the external-port word three edges after a pin change. A broken end-of-interrupt path shows as a pulse that is missing, lands on the wrong bits, or lasts longer than one cycle.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  // Number of stored split configuration registers, placed every 8 bytes.
  localparam int N_CFG = 10;

  // Configuration register order (index k, byte offset 8*k).
  localparam int K_OUT     = 0;
  localparam int K_DIR     = 1;
  localparam int K_IEN     = 2;
  localparam int K_IMASK   = 3;
  localparam int K_IEDGE   = 4;
  localparam int K_IPOL    = 5;
  localparam int K_IBOTH   = 6;
  localparam int K_DEB     = 7;
  localparam int K_DIVEN   = 8;
  localparam int K_DIVVAL  = 9;

  // Pulse-only register slot (byte offset 8*K_EOI).
  localparam int K_EOI = 12;

  // Word indices (byte offset / 4) of read-only words.
  localparam int W_STAT = 20;
  localparam int W_RAW  = 22;
  localparam int W_EXT  = 28;
  localparam int W_VER  = 30;

  localparam logic [31:0] LAYOUT_ID = 32'h0100_0C2B;
endpackage

// File: rtl/gpio_mw_split_reg.sv
// One logical register held as two halves. Each half takes a masked write:
// the upper part of the write word enables the matching lower-part bits.
// PULSE=0 stores the result; PULSE=1 emits it for one cycle only.
module gpio_mw_split_reg #(
  parameter int HALF  = 16,
  parameter bit PULSE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel_lo,
  input  logic              sel_hi,
  input  logic [2*HALF-1:0] wdata,
  output logic [2*HALF-1:0] q
);
  localparam int W = 2 * HALF;

  logic [HALF-1:0] en_bits;
  logic [HALF-1:0] val_bits;

  assign en_bits  = wdata[W-1:HALF];
  assign val_bits = wdata[HALF-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic hit;
    logic [HALF-1:0] cur;

    assign hit = we & ((h == 0) ? sel_lo : sel_hi);
    assign q[h*HALF +: HALF] = cur;

    if (PULSE) begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst)      cur <= '0;
        else if (hit) cur <= en_bits & val_bits;
        else          cur <= '0;
      end
    end else begin : g_store
      always_ff @(posedge clk) begin
        if (rst)      cur <= '0;
        else if (hit) cur <= (cur & ~en_bits) | (val_bits & en_bits);
      end
    end
  end
endmodule

// File: rtl/gpio_mw_in_sync.sv
// Multi-flop synchronizer for the asynchronous pin inputs.
module gpio_mw_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_mw_rd_mux.sv
// Registered read-data selection by word index.
module gpio_mw_rd_mux
  import gpio_mw_pkg::*;
#(
  parameter int PINS   = 32,
  parameter int WORD_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WORD_W-1:0]          word,
  input  logic [N_CFG-1:0][PINS-1:0] cfg,
  input  logic [PINS-1:0]            stat,
  input  logic [PINS-1:0]            raw,
  input  logic [PINS-1:0]            ext,
  output logic [PINS-1:0]            rdata
);
  localparam int HALF = PINS / 2;

  logic [WORD_W-2:0] slot;
  logic [PINS-1:0]   nxt;

  assign slot = word[WORD_W-1:1];

  always_comb begin
    nxt = '0;
    for (int k = 0; k < N_CFG; k++) begin
      if (slot == (WORD_W-1)'(k)) begin
        nxt = {{HALF{1'b0}}, (word[0] ? cfg[k][PINS-1:HALF] : cfg[k][HALF-1:0])};
      end
    end
    if (word == WORD_W'(W_STAT)) nxt = stat;
    if (word == WORD_W'(W_RAW))  nxt = raw;
    if (word == WORD_W'(W_EXT))  nxt = ext;
    if (word == WORD_W'(W_VER))  nxt = LAYOUT_ID;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= nxt;
  end
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
  import gpio_mw_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   irq_en,
  output logic [PINS-1:0]   irq_mask,
  output logic [PINS-1:0]   irq_edge,
  output logic [PINS-1:0]   irq_pol,
  output logic [PINS-1:0]   irq_both,
  output logic [PINS-1:0]   deb_en,
  output logic [PINS-1:0]   deb_div_en,
  output logic [PINS-1:0]   deb_div_val,
  input  logic [PINS-1:0]   irq_stat_in,
  input  logic [PINS-1:0]   irq_raw_in,
  output logic [PINS-1:0]   eoi_pulse
);
  localparam int HALF   = PINS / 2;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0]          word;
  logic [N_CFG-1:0][PINS-1:0] cfg;
  logic [PINS-1:0]            ext_sync;

  assign word = bus_addr[ADDR_W-1:2];

  for (genvar k = 0; k < N_CFG; k++) begin : g_cfg
    gpio_mw_split_reg #(.HALF(HALF), .PULSE(1'b0)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .we     (bus_we),
      .sel_lo (word == WORD_W'(2*k)),
      .sel_hi (word == WORD_W'(2*k+1)),
      .wdata  (bus_wdata),
      .q      (cfg[k])
    );
  end

  gpio_mw_split_reg #(.HALF(HALF), .PULSE(1'b1)) u_eoi (
    .clk    (clk),
    .rst    (rst),
    .we     (bus_we),
    .sel_lo (word == WORD_W'(2*K_EOI)),
    .sel_hi (word == WORD_W'(2*K_EOI+1)),
    .wdata  (bus_wdata),
    .q      (eoi_pulse)
  );

  gpio_mw_in_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (ext_sync)
  );

  gpio_mw_rd_mux #(.PINS(PINS), .WORD_W(WORD_W)) u_rd (
    .clk   (clk),
    .rst   (rst),
    .word  (word),
    .cfg   (cfg),
    .stat  (irq_stat_in),
    .raw   (irq_raw_in),
    .ext   (ext_sync),
    .rdata (bus_rdata)
  );

  assign pin_out     = cfg[K_OUT];
  assign pin_oe      = cfg[K_DIR];
  assign irq_en      = cfg[K_IEN];
  assign irq_mask    = cfg[K_IMASK];
  assign irq_edge    = cfg[K_IEDGE];
  assign irq_pol     = cfg[K_IPOL];
  assign irq_both    = cfg[K_IBOTH];
  assign deb_en      = cfg[K_DEB];
  assign deb_div_en  = cfg[K_DIVEN];
  assign deb_div_val = cfg[K_DIVVAL];
endmodule

// File: rtl/gpio_mw_bank_chk.sv
module gpio_mw_bank_chk #(
  parameter int PINS   = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PINS-1:0]   bus_wdata,
  input logic              bus_we,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   eoi_pulse
);
  localparam int HALF = PINS / 2;
  logic [ADDR_W-3:0] word;
  assign word = bus_addr[ADDR_W-1:2];

  // R2
  masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && word == '0) |=> pin_out[HALF-1:0] ==
      (($past(pin_out[HALF-1:0]) & ~$past(bus_wdata[PINS-1:HALF])) |
       ($past(bus_wdata[HALF-1:0]) & $past(bus_wdata[PINS-1:HALF]))));

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

  // R6
  version_read_chk: assert property (@(posedge clk) disable iff (rst)
    (word == (ADDR_W-2)'(30)) |=> bus_rdata == 32'h0100_0C2B);

  // R9
  eoi_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_we |=> eoi_pulse == '0);

  // R5
  split_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (word < (ADDR_W-2)'(20)) |=> bus_rdata[PINS-1:HALF] == '0);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0));
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .eoi_pulse (eoi_pulse)
);

// File: tb/tb_gpio_mw_bank.sv
module tb_gpio_mw_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, irq_en, irq_mask, irq_edge, irq_pol, irq_both;
  logic [31:0] deb_en, deb_div_en, deb_div_val;
  logic [31:0] irq_stat_in = '0;
  logic [31:0] irq_raw_in = '0;
  logic [31:0] eoi_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_mw_bank dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_en(irq_en), .irq_mask(irq_mask),
    .irq_edge(irq_edge), .irq_pol(irq_pol), .irq_both(irq_both),
    .deb_en(deb_en), .deb_div_en(deb_div_en), .deb_div_val(deb_div_val),
    .irq_stat_in(irq_stat_in), .irq_raw_in(irq_raw_in), .eoi_pulse(eoi_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #2 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] out_of(input int k);
    case (k)
      0: out_of = pin_out;     1: out_of = pin_oe;
      2: out_of = irq_en;      3: out_of = irq_mask;
      4: out_of = irq_edge;    5: out_of = irq_pol;
      6: out_of = irq_both;    7: out_of = deb_en;
      8: out_of = deb_div_en;  default: out_of = deb_div_val;
    endcase
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    check(pin_oe == 0, "R10 oe", pin_oe, 0);
    check(pin_out == 0 && irq_en == 0, "R10 out/ien", pin_out | irq_en, 0);
    rd(8'h08, v);
    check(v == 0, "R10 dir read", v, 0);
  endtask

  task automatic t_masked_write();
    wr(8'h00, 32'hFFFF_A5A5);
    check(pin_out == 32'h0000_A5A5, "R3 full write", pin_out, 32'h0000_A5A5);
    wr(8'h00, 32'h0003_0002);
    check(pin_out == 32'h0000_A5A6, "R2 masked bits 0-1", pin_out, 32'h0000_A5A6);
    wr(8'h00, 32'h0000_FFFF);
    check(pin_out == 32'h0000_A5A6, "R2 no enables", pin_out, 32'h0000_A5A6);
    wr(8'h04, 32'h8001_8001);
    check(pin_out == 32'h8001_A5A6, "R1 upper half", pin_out, 32'h8001_A5A6);
    wr(8'h04, 32'h8000_0000);
    check(pin_out == 32'h0001_A5A6, "R3 clear bit 31", pin_out, 32'h0001_A5A6);
  endtask

  task automatic t_direction();
    wr(8'h08, 32'h0010_0010);
    wr(8'h0C, 32'h0004_0004);
    check(pin_oe == 32'h0004_0010, "R4 oe pins 4,18", pin_oe, 32'h0004_0010);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    rd(8'h00, v);
    check(v == 32'h0000_A5A6, "R5 read low", v, 32'h0000_A5A6);
    rd(8'h04, v);
    check(v == 32'h0000_0001, "R5 read high", v, 32'h0000_0001);
  endtask

  task automatic t_config();
    logic [31:0] v;
    for (int k = 2; k < 10; k++) begin
      logic [15:0] lo, hi;
      lo = 16'(k * 16'h0111);
      hi = 16'(k * 16'h1003);
      wr(8'(8*k), {16'hFFFF, lo});
      wr(8'(8*k+4), {16'hFFFF, hi});
      v = out_of(k);
      check(v == {hi, lo}, $sformatf("R1 reg k=%0d output", k), v, {hi, lo});
      rd(8'(8*k+4), v);
      check(v == {16'h0, hi}, $sformatf("R5 reg k=%0d read", k), v, {16'h0, hi});
    end
  endtask

  task automatic t_version();
    logic [31:0] v;
    wr(8'h78, 32'hFFFF_0000);
    rd(8'h78, v);
    check(v == 32'h0100_0C2B, "R6 version", v, 32'h0100_0C2B);
  endtask

  task automatic t_extport();
    logic [31:0] v;
    @(negedge clk) pin_in = 32'hDEAD_BEEF;
    wr(8'h70, 32'hFFFF_0000);
    repeat (3) @(negedge clk);
    rd(8'h70, v);
    check(v == 32'hDEAD_BEEF, "R7 ext port", v, 32'hDEAD_BEEF);
    @(negedge clk) begin pin_in = 32'h1234_5678; bus_addr = 8'h70; end
    @(posedge clk); @(negedge clk);
    check(bus_rdata == 32'hDEAD_BEEF, "R7 sync delay", bus_rdata, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    check(bus_rdata == 32'h1234_5678, "R7 after sync", bus_rdata, 32'h1234_5678);
  endtask

  task automatic t_status();
    logic [31:0] v;
    irq_stat_in = 32'h8000_0421;
    irq_raw_in  = 32'hF0F0_0001;
    rd(8'h50, v);
    check(v == 32'h8000_0421, "R8 status", v, 32'h8000_0421);
    rd(8'h58, v);
    check(v == 32'hF0F0_0001, "R8 raw", v, 32'hF0F0_0001);
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    wr(8'h60, 32'h00F0_0FF0);
    check(eoi_pulse == 32'h0000_00F0, "R9 eoi low", eoi_pulse, 32'h0000_00F0);
    @(posedge clk); #2;
    check(eoi_pulse == 0, "R9 eoi one cycle", eoi_pulse, 0);
    wr(8'h64, 32'h8001_8001);
    check(eoi_pulse == 32'h8001_0000, "R9 eoi high", eoi_pulse, 32'h8001_0000);
    rd(8'h60, v);
    check(v == 0, "R9 eoi reads zero", v, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v, oe0, out0;
    oe0 = pin_oe; out0 = pin_out;
    wr(8'h54, 32'hFFFF_FFFF);
    wr(8'h7C, 32'hFFFF_FFFF);
    wr(8'hC0, 32'hFFFF_FFFF);
    check(pin_oe == oe0 && pin_out == out0, "R11 writes ignored", pin_oe, oe0);
    rd(8'h54, v);
    check(v == 0, "R11 read 0x54", v, 0);
    rd(8'hC0, v);
    check(v == 0, "R11 read 0xC0", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    t_masked_write();
    t_direction();
    t_readback();
    t_config();
    t_version();
    t_extport();
    t_status();
    t_eoi();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule